// File: doc/BRIEF.md
# Conditional execute and trap unit

This unit sits in the execute stage of a small 32-bit processor. It keeps the four arithmetic flags (negative, zero, carry, overflow) in a register. Every instruction word that reaches the stage carries a 4-bit condition code in its top nibble. The unit tests that code against the stored flags and either lets the instruction execute or squashes it. A compare instruction that executes loads fresh flags from the ALU. The next instruction tests its condition against those new flags.

A software-interrupt instruction is marked by its tag nibble. When its condition passes, the unit raises a one-cycle trap request. At the same edge it captures the 24-bit call number and switches the processor from user mode to supervisor mode. A software interrupt whose condition fails does nothing, and execution continues with the next word.

The instruction input is a plain valid strobe with no back-pressure. The unit decides in the same cycle for every word presented, so it never stalls the stage and has no ready output.

Top module: `cond_trap_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags, clears `call_num` to zero and sets the mode to user (`mode_super` = 0).
- R2: The condition code is `ins_word[31:28]`. Code 0 passes when Z=1 and code 1 passes when Z=0. Codes 2 and 3 do the same for C, codes 4 and 5 for N, and codes 6 and 7 for V.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N equals V, and code 11 passes when they differ. Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R5: Code 14 passes regardless of the flags. Code 15 never passes, so its instruction is a no-op.
- R6: `exec_en` is high in a cycle exactly when `ins_valid` is high and the condition passes. With `ins_valid` low, neither `exec_en` nor `trap_req` is asserted.
- R7: When an executing instruction has `alu_flag_upd` high, the flags take `alu_nzcv` at the next edge, ordered {N,Z,C,V} from bit 3 down to bit 0. An instruction that is squashed or not valid leaves the flags unchanged.
- R8: A word with `ins_word[27:24]` = 4'b1111 is a software interrupt. If it executes, `trap_req` is high in that same cycle. After the next edge `mode_super` is 1 and `call_num` equals that word's bits 23:0.
- R9: A software interrupt whose condition fails raises no trap and leaves the mode and `call_num` unchanged.
- R10: A word whose bits 27:24 are not 4'b1111 never raises `trap_req`.
- R11: Once in supervisor mode, the unit stays there until reset. A later executing software interrupt still replaces `call_num`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word present this cycle |
| ins_word | input | 32 | Instruction: condition [31:28], tag [27:24], call number [23:0] |
| alu_flag_upd | input | 1 | The instruction writes the flags (compare) |
| alu_nzcv | input | 4 | ALU flag results {N,Z,C,V} |
| exec_en | output | 1 | Instruction executes (condition passed) |
| trap_req | output | 1 | One-cycle software-interrupt trap request |
| call_num | output | 24 | Call number captured at the last trap |
| mode_super | output | 1 | 1 = supervisor mode, 0 = user mode |

## Verification
The bench sweeps all sixteen flag values against all sixteen condition codes, for ordinary words and for software interrupts. A wrong row in the condition table, or one that swaps a set-test with its clear-test, shows up there as a wrong `exec_en` or a spurious or missing trap. The never code is swept too, so a design that treats it as always would execute words and trap when it should not. Flag writes are probed through ordinary conditional words after an invalid compare and after a squashed compare. A design that updated flags without gating them on the pass result would show changed flags there. Mode and call number are read one cycle after each trap, which catches an off-by-one edge or a number captured from the wrong word.

// File: rtl/cxt_pkg.sv
package cxt_pkg;

  localparam int COND_W    = 4;
  localparam int TAG_W     = 4;
  localparam int NUM_CODES = 1 << COND_W;
  localparam int NUM_PAIRS = NUM_CODES / 2;
  localparam logic [TAG_W-1:0] SWI_TAG = '1;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic {
    MODE_USER  = 1'b0,
    MODE_SUPER = 1'b1
  } mode_e;

  // Even code of each pair tests this term; the odd code tests its inverse.
  function automatic logic pair_base(input int k, input nzcv_t f);
    logic r;
    case (k)
      0:       r = f.z;
      1:       r = f.c;
      2:       r = f.n;
      3:       r = f.v;
      4:       r = f.c & ~f.z;
      5:       r = (f.n == f.v);
      6:       r = ~f.z & (f.n == f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cxt_cond_eval.sv
module cxt_cond_eval
  import cxt_pkg::*;
(
  input  nzcv_t             flags,
  input  logic [COND_W-1:0] cond,
  output logic              pass
);

  logic [NUM_PAIRS-1:0] base;
  logic [NUM_CODES-1:0] pass_vec;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign base[k]          = pair_base(k, flags);
    assign pass_vec[2*k]    = base[k];
    assign pass_vec[2*k+1]  = ~base[k];
  end

  assign pass = pass_vec[cond];

endmodule

// File: rtl/cxt_flag_reg.sv
module cxt_flag_reg
  import cxt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  nzcv_t d,
  output nzcv_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/cxt_trap_ctrl.sv
module cxt_trap_ctrl
  import cxt_pkg::*;
#(
  parameter int CALL_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_ok,
  input  logic [TAG_W-1:0]  tag,
  input  logic [CALL_W-1:0] num,
  output logic              trap,
  output logic [CALL_W-1:0] num_q,
  output mode_e             mode_q
);

  assign trap = exec_ok && (tag == SWI_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_USER;
      num_q  <= '0;
    end else if (trap) begin
      mode_q <= MODE_SUPER;
      num_q  <= num;
    end
  end

endmodule

// File: rtl/cond_trap_unit.sv
module cond_trap_unit
  import cxt_pkg::*;
#(
  parameter  int CALL_W = 24,
  localparam int WORD_W = CALL_W + TAG_W + COND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [WORD_W-1:0] ins_word,
  input  logic              alu_flag_upd,
  input  logic [3:0]        alu_nzcv,
  output logic              exec_en,
  output logic              trap_req,
  output logic [CALL_W-1:0] call_num,
  output logic              mode_super
);

  localparam int TAG_LSB  = CALL_W;
  localparam int COND_LSB = CALL_W + TAG_W;

  nzcv_t flags_q;
  nzcv_t flags_d;
  logic  cond_pass;
  mode_e mode_q;

  assign flags_d = nzcv_t'(alu_nzcv);

  cxt_cond_eval u_eval (
    .flags (flags_q),
    .cond  (ins_word[COND_LSB +: COND_W]),
    .pass  (cond_pass)
  );

  assign exec_en = ins_valid & cond_pass;

  cxt_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .we  (exec_en & alu_flag_upd),
    .d   (flags_d),
    .q   (flags_q)
  );

  cxt_trap_ctrl #(.CALL_W(CALL_W)) u_trap (
    .clk     (clk),
    .rst     (rst),
    .exec_ok (exec_en),
    .tag     (ins_word[TAG_LSB +: TAG_W]),
    .num     (ins_word[CALL_W-1:0]),
    .trap    (trap_req),
    .num_q   (call_num),
    .mode_q  (mode_q)
  );

  assign mode_super = (mode_q == MODE_SUPER);

endmodule

// File: rtl/cond_trap_unit_chk.sv
module cond_trap_unit_chk #(
  parameter int CALL_W = 24,
  localparam int WORD_W = CALL_W + 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ins_valid,
  input logic [WORD_W-1:0] ins_word,
  input logic              exec_en,
  input logic              trap_req,
  input logic [CALL_W-1:0] call_num,
  input logic              mode_super
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |-> (!exec_en && !trap_req)); // R6

  AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_word[WORD_W-1 -: 4] == 4'hE) |-> exec_en); // R5

  AST_NEVER_RUNS: assert property (@(posedge clk) disable iff (rst)
    (ins_word[WORD_W-1 -: 4] == 4'hF) |-> (!exec_en && !trap_req)); // R5

  AST_TRAP_EXECUTES: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> exec_en); // R8

  AST_TRAP_ENTERS_SUPER: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> mode_super); // R8

  AST_TRAP_CAPTURES_NUM: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (call_num == $past(ins_word[CALL_W-1:0]))); // R8

  AST_NUM_HELD: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> $stable(call_num)); // R9

  AST_MODE_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_super) |-> $past(trap_req)); // R9

  AST_NON_SWI_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (ins_word[CALL_W +: 4] != 4'hF) |-> !trap_req); // R10

  AST_SUPER_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode_super |=> mode_super); // R11

endmodule

bind cond_trap_unit cond_trap_unit_chk #(.CALL_W(CALL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ins_valid  (ins_valid),
  .ins_word   (ins_word),
  .exec_en    (exec_en),
  .trap_req   (trap_req),
  .call_num   (call_num),
  .mode_super (mode_super)
);

// File: tb/cond_trap_unit_bench.sv
`timescale 1ns/1ps
module cond_trap_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_word = '0;
  logic        alu_flag_upd = 1'b0;
  logic [3:0]  alu_nzcv = '0;
  logic        exec_en;
  logic        trap_req;
  logic [23:0] call_num;
  logic        mode_super;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cond_trap_unit u_cond_trap_unit (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
    .alu_flag_upd(alu_flag_upd), .alu_nzcv(alu_nzcv), .exec_en(exec_en),
    .trap_req(trap_req), .call_num(call_num), .mode_super(mode_super)
  );

  function automatic bit model(input int code, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    if (code < 8)  return "R2";
    if (code < 10) return "R3";
    if (code < 14) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic upd, input logic [3:0] f);
    @(negedge clk);
    ins_valid = v; ins_word = w; alu_flag_upd = upd; alu_nzcv = f;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ins_valid = 1'b0; alu_flag_upd = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_flags(input logic [3:0] f);
    drive(1'b1, {4'hE, 4'h1, 24'h0}, 1'b1, f);
  endtask

  // Reads the flags back through codes 0, 2, 4 and 6 (Z, C, N, V).
  task automatic probe(output logic [3:0] f);
    drive(1'b1, {4'h0, 4'h2, 24'h0}, 1'b0, 4'h0); f[2] = exec_en;
    drive(1'b1, {4'h2, 4'h2, 24'h0}, 1'b0, 4'h0); f[1] = exec_en;
    drive(1'b1, {4'h4, 4'h2, 24'h0}, 1'b0, 4'h0); f[3] = exec_en;
    drive(1'b1, {4'h6, 4'h2, 24'h0}, 1'b0, 4'h0); f[0] = exec_en;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] pf;
    logic [23:0] num;
    bit exp_pass;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 mode", 32'(mode_super), 0);
    chk("R1 call_num", 32'(call_num), 0);
    rst = 1'b0;
    probe(pf);
    chk("R1 flags", 32'(pf), 0);

    // R2..R5, R6, R10: full flag x condition sweep on ordinary words
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        load_flags(4'(f));
        chk("R6 load exec", 32'(exec_en), 1);
        drive(1'b1, {4'(c), 4'(c ^ 5), 24'h0}, 1'b0, 4'h0);
        if ((c ^ 5) != 15) begin
          chk(tag_of(c), 32'(exec_en), 32'(model(c, 4'(f))));
          chk("R10 no trap", 32'(trap_req), 0);
        end
      end
    end

    // R6 / R7: invalid and squashed compares keep the flags
    load_flags(4'b0101);
    drive(1'b0, {4'hE, 4'hF, 24'h123456}, 1'b1, 4'b1010);
    chk("R6 idle exec", 32'(exec_en), 0);
    chk("R6 idle trap", 32'(trap_req), 0);
    probe(pf);
    chk("R7 invalid keeps", 32'(pf), 32'b0101);
    drive(1'b1, {4'hF, 4'h1, 24'h0}, 1'b1, 4'b1111);
    chk("R5 never exec", 32'(exec_en), 0);
    probe(pf);
    chk("R7 never keeps", 32'(pf), 32'b0101);
    drive(1'b1, {4'h0, 4'h1, 24'h0}, 1'b1, 4'b0011);
    probe(pf);
    chk("R7 cond write", 32'(pf), 32'b0011);
    drive(1'b1, {4'h0, 4'h1, 24'h0}, 1'b1, 4'b1100);
    probe(pf);
    chk("R7 squashed keeps", 32'(pf), 32'b0011);
    drive(1'b1, {4'hE, 4'h1, 24'h0}, 1'b1, 4'b1000);
    drive(1'b1, {4'h4, 4'h2, 24'h0}, 1'b0, 4'h0);
    chk("R7 next sees new", 32'(exec_en), 1);

    // R8 / R9: software interrupt sweep
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        do_reset();
        load_flags(4'(f));
        num = {4'(f), 4'(c), 16'hC35A};
        exp_pass = model(c, 4'(f));
        drive(1'b1, {4'(c), 4'hF, num}, 1'b0, 4'h0);
        chk(exp_pass ? "R8 trap" : "R9 no trap", 32'(trap_req), 32'(exp_pass));
        drive(1'b0, 32'h0, 1'b0, 4'h0);
        chk(exp_pass ? "R8 mode" : "R9 mode", 32'(mode_super), 32'(exp_pass));
        chk(exp_pass ? "R8 num" : "R9 num", 32'(call_num), exp_pass ? 32'(num) : 0);
      end
    end

    // R11: supervisor mode is sticky; later traps replace the number
    do_reset();
    drive(1'b1, {4'hE, 4'hF, 24'hABCDEF}, 1'b0, 4'h0);
    drive(1'b1, {4'hE, 4'h3, 24'h111111}, 1'b0, 4'h0);
    chk("R11 mode held", 32'(mode_super), 1);
    drive(1'b1, {4'hF, 4'hF, 24'h222222}, 1'b0, 4'h0);
    chk("R9 never swi", 32'(trap_req), 0);
    drive(1'b1, {4'hE, 4'hF, 24'h333333}, 1'b0, 4'h0);
    chk("R11 mode held", 32'(mode_super), 1);
    chk("R9 num held", 32'(call_num), 32'hABCDEF);
    drive(1'b0, 32'h0, 1'b0, 4'h0);
    chk("R11 num replaced", 32'(call_num), 32'h333333);
    chk("R11 mode held", 32'(mode_super), 1);
    do_reset();
    #1;
    chk("R1 mode after reset", 32'(mode_super), 0);
    chk("R1 num after reset", 32'(call_num), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule